// File: doc/BRIEF.md
# Dual-Bank GPIO Port Controller

This block controls general-purpose I/O pins, grouped into ports of `WIDTH` pins each (two ports of 32 pins by default). Each port keeps two separate sets of output and direction state. The legacy bank sits on a plain word-wide register interface. The fast bank sits on a second register interface and adds two features: a per-port write mask and byte-lane enables on every write. A per-port mode input picks which bank drives that port's pins. The state held in the other bank stays as it is and can still be read, but it has no effect on the pins.

Both interfaces are synchronous and take word addresses. A write is accepted on the clock edge at which enable and write are both high. Read data is combinational from the addressed register. It is zero when the interface is idle, during a write, and for an unmapped offset.

Incoming pin levels pass through a two-flop synchronizer. The pin register of either bank returns the synchronized levels whatever the pin direction. Legacy word offsets within a port are: pin value 0, set 1, direction 2, clear 3. The port index sits in the address bits above those two bits.

Fast-bank word offsets within a port are: direction 0, mask 1, pin value 2, set 3, clear 4. Offsets 5 to 7 are unmapped, and the port index sits in the address bits above those three bits.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, every output latch, direction register and mask register is zero. As a result, `pin_oe` is all zero in the cycle after reset.
- R2: A read of the pin register in either bank returns the pin levels that were on `pin_i` at least two clock edges earlier, for input and output pins alike. In the fast bank, masked bits are the exception (see R9).
- R3: In the legacy bank, a write to the set register ORs the written ones into the output latch, and zero bits leave the latch unchanged. A write to the legacy pin register loads the output latch with the written word. A read of the set register returns the latch.
- R4: In either bank, writing a 1 to a bit of the clear register drives that output latch bit to 0. Zero bits have no effect.
- R5: The clear registers read as 0. Fast-bank offsets 5, 6 and 7 read as 0, and writes to them change no register.
- R6: The two banks, and the ports within a bank, hold separate state. A write through one bank or to one port leaves every other bank's and every other port's registers unchanged when read back.
- R7: For each port, `fast_mode[p]`=1 drives that port's pins from the fast bank's output latch and direction. `fast_mode[p]`=0 drives them from the legacy bank.
- R8: In the fast bank, bits set to 1 in the mask register are left unchanged by writes to the set, clear and pin registers.
- R9: A read of the fast pin register returns 0 in every bit that is masked.
- R10: In the fast bank, `fs_be[k]` gates pins 8k to 8k+7 on every write. Lanes whose enable is 0 are left unchanged in the direction, mask and output registers.
- R11: A write to the fast pin register loads the written value into the output latch bits that are both unmasked and byte-enabled.
- R12: `pin_oe` bit i is 1 exactly when direction bit i of the active bank is 1, and `pin_o` then carries that bank's output latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | NPORTS | Per-port bank select, 1 = fast bank drives the pins |
| lg_en | input | 1 | Legacy interface access enable |
| lg_we | input | 1 | Legacy write (1) or read (0) |
| lg_addr | input | PORT_BITS+2 | Legacy word address {port, offset[1:0]} |
| lg_wdata | input | WIDTH | Legacy write data |
| lg_rdata | output | WIDTH | Legacy read data |
| fs_en | input | 1 | Fast interface access enable |
| fs_we | input | 1 | Fast write (1) or read (0) |
| fs_addr | input | PORT_BITS+3 | Fast word address {port, offset[2:0]} |
| fs_be | input | WIDTH/8 | Fast byte-lane write enables |
| fs_wdata | input | WIDTH | Fast write data |
| fs_rdata | output | WIDTH | Fast read data |
| pin_i | input | NPORTS*WIDTH | Pin levels from the pads |
| pin_o | output | NPORTS*WIDTH | Output levels to the pads |
| pin_oe | output | NPORTS*WIDTH | Per-pin output enable |

## Verification
A legacy-bank write and a fast-bank write can land on the same clock edge, and both can target the same port. The bench provokes this with a single task that drives both interfaces in one cycle. In that cycle the legacy interface sets one pin and the fast interface sets another pin of the same port. Each bank's set register is then read back, and each must show only its own write. The port's `fast_mode` bit is then flipped, and `pin_o` must follow whichever bank is selected.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

    // Legacy bank word offsets within one port
    typedef enum logic [1:0] {
        LG_PIN = 2'd0,
        LG_SET = 2'd1,
        LG_DIR = 2'd2,
        LG_CLR = 2'd3
    } lg_reg_e;

    // Fast bank word offsets within one port (5..7 unmapped)
    typedef enum logic [2:0] {
        FS_DIR  = 3'd0,
        FS_MASK = 3'd1,
        FS_PIN  = 3'd2,
        FS_SET  = 3'd3,
        FS_CLR  = 3'd4
    } fs_reg_e;

    // Decoded access to one port of one bank
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [2:0] idx;
    } gpio_acc_t;

    function automatic gpio_acc_t make_acc(input logic hit, input logic we,
                                           input logic [2:0] idx);
        gpio_acc_t a;
        a.wr  = hit & we;
        a.rd  = hit & ~we;
        a.idx = idx;
        return a;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_lg_bank.sv
module gpio_lg_bank
    import gpio_dual_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  gpio_acc_t    acc,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rdata
);
    logic [1:0] ofs;
    assign ofs = acc.idx[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (acc.wr) begin
            case (lg_reg_e'(ofs))
                LG_PIN: out_q <= wdata;
                LG_SET: out_q <= out_q | wdata;
                LG_DIR: dir_q <= wdata;
                LG_CLR: out_q <= out_q & ~wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.rd) begin
            case (lg_reg_e'(ofs))
                LG_PIN: rdata = pin_sync;
                LG_SET: rdata = out_q;
                LG_DIR: rdata = dir_q;
                default: rdata = '0;
            endcase
        end
    end

    // R3: set write ORs into the latch
    a_r3_set_or: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && ofs == LG_SET) |=> out_q == ($past(out_q) | $past(wdata)));

    // R4: clear write removes ones only
    a_r4_clr_and: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && ofs == LG_CLR) |=> out_q == ($past(out_q) & ~$past(wdata)));

    // R6: no write here leaves this bank untouched
    a_r6_lg_hold: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_fs_bank.sv
module gpio_fs_bank
    import gpio_dual_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  gpio_acc_t      acc,
    input  logic [W/8-1:0] be,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   pin_sync,
    output logic [W-1:0]   out_q,
    output logic [W-1:0]   dir_q,
    output logic [W-1:0]   rdata
);
    localparam int NLANE = W / 8;

    logic [W-1:0] mask_q;
    logic [W-1:0] lane;
    logic [W-1:0] eff;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane[g*8 +: 8] = {8{be[g]}};
    end

    assign eff = lane & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (acc.wr) begin
            case (acc.idx)
                FS_DIR:  dir_q  <= (dir_q & ~lane) | (wdata & lane);
                FS_MASK: mask_q <= (mask_q & ~lane) | (wdata & lane);
                FS_PIN:  out_q  <= (out_q & ~eff) | (wdata & eff);
                FS_SET:  out_q  <= out_q | (wdata & eff);
                FS_CLR:  out_q  <= out_q & ~(wdata & eff);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.rd) begin
            case (acc.idx)
                FS_DIR:  rdata = dir_q;
                FS_MASK: rdata = mask_q;
                FS_PIN:  rdata = pin_sync & ~mask_q;
                FS_SET:  rdata = out_q;
                default: rdata = '0;
            endcase
        end
    end

    // R8: masked output bits never move on a write
    a_r8_mask_guard: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> (out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q)));

    // R10: disabled lanes of the direction register stay put
    a_r10_dir_lanes: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.idx == FS_DIR) |=> (dir_q & ~$past(lane)) == ($past(dir_q) & ~$past(lane)));

    // R6: no write here leaves this bank untouched
    a_r6_fs_hold: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_dual_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int NPORTS    = 2,
    parameter int PORT_BITS = $clog2(NPORTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORTS-1:0]         fast_mode,
    input  logic                      lg_en,
    input  logic                      lg_we,
    input  logic [PORT_BITS+1:0]      lg_addr,
    input  logic [WIDTH-1:0]          lg_wdata,
    output logic [WIDTH-1:0]          lg_rdata,
    input  logic                      fs_en,
    input  logic                      fs_we,
    input  logic [PORT_BITS+2:0]      fs_addr,
    input  logic [WIDTH/8-1:0]        fs_be,
    input  logic [WIDTH-1:0]          fs_wdata,
    output logic [WIDTH-1:0]          fs_rdata,
    input  logic [NPORTS*WIDTH-1:0]   pin_i,
    output logic [NPORTS*WIDTH-1:0]   pin_o,
    output logic [NPORTS*WIDTH-1:0]   pin_oe
);
    localparam int TOTAL = NPORTS * WIDTH;

    logic [TOTAL-1:0]     pin_sync;
    logic [PORT_BITS-1:0] lg_port;
    logic [PORT_BITS-1:0] fs_port;
    logic [WIDTH-1:0]     lg_rd [NPORTS];
    logic [WIDTH-1:0]     fs_rd [NPORTS];

    assign lg_port = lg_addr[2 +: PORT_BITS];
    assign fs_port = fs_addr[3 +: PORT_BITS];

    gpio_sync2 #(.W(TOTAL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [WIDTH-1:0] lg_out, lg_dir, fs_out, fs_dir;
        gpio_acc_t        lg_acc, fs_acc;

        assign lg_acc = make_acc(lg_en && lg_port == PORT_BITS'(p), lg_we,
                                 {1'b0, lg_addr[1:0]});
        assign fs_acc = make_acc(fs_en && fs_port == PORT_BITS'(p), fs_we,
                                 fs_addr[2:0]);

        gpio_lg_bank #(.W(WIDTH)) u_lg (
            .clk      (clk),
            .rst      (rst),
            .acc      (lg_acc),
            .wdata    (lg_wdata),
            .pin_sync (pin_sync[p*WIDTH +: WIDTH]),
            .out_q    (lg_out),
            .dir_q    (lg_dir),
            .rdata    (lg_rd[p])
        );

        gpio_fs_bank #(.W(WIDTH)) u_fs (
            .clk      (clk),
            .rst      (rst),
            .acc      (fs_acc),
            .be       (fs_be),
            .wdata    (fs_wdata),
            .pin_sync (pin_sync[p*WIDTH +: WIDTH]),
            .out_q    (fs_out),
            .dir_q    (fs_dir),
            .rdata    (fs_rd[p])
        );

        assign pin_o[p*WIDTH +: WIDTH]  = fast_mode[p] ? fs_out : lg_out;
        assign pin_oe[p*WIDTH +: WIDTH] = fast_mode[p] ? fs_dir : lg_dir;
    end

    always_comb begin
        lg_rdata = '0;
        fs_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            lg_rdata |= lg_rd[p];
            fs_rdata |= fs_rd[p];
        end
    end

    // R1: all output enables off in the cycle after reset
    a_r1_oe_off_after_reset: assert property (@(posedge clk)
        rst |=> pin_oe == '0);

    // R5: a read of a clear register returns zero
    a_r5_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (lg_en && !lg_we && lg_addr[1:0] == LG_CLR) |-> lg_rdata == '0);
endmodule

// File: tb/gpio_dual_bank_bench.sv
module gpio_dual_bank_bench;
    localparam int W  = 32;
    localparam int NP = 2;

    logic          clk = 0;
    logic          rst;
    logic [NP-1:0] fast_mode;
    logic          lg_en, lg_we;
    logic [2:0]    lg_addr;
    logic [W-1:0]  lg_wdata, lg_rdata;
    logic          fs_en, fs_we;
    logic [3:0]    fs_addr;
    logic [3:0]    fs_be;
    logic [W-1:0]  fs_wdata, fs_rdata;
    logic [NP*W-1:0] pin_i, pin_o, pin_oe;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] lg_exp_q[$];
    string        lg_tag_q[$];
    logic [W-1:0] fs_exp_q[$];
    string        fs_tag_q[$];

    always #5 clk = ~clk;

    gpio_dual_bank u_gpio_dual_bank (
        .clk(clk), .rst(rst), .fast_mode(fast_mode),
        .lg_en(lg_en), .lg_we(lg_we), .lg_addr(lg_addr),
        .lg_wdata(lg_wdata), .lg_rdata(lg_rdata),
        .fs_en(fs_en), .fs_we(fs_we), .fs_addr(fs_addr), .fs_be(fs_be),
        .fs_wdata(fs_wdata), .fs_rdata(fs_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare reads at the falling edge, while the request is held
    always @(negedge clk) begin
        if (!rst && lg_en && !lg_we && lg_exp_q.size() > 0)
            check(lg_tag_q.pop_front(), 64'(lg_rdata), 64'(lg_exp_q.pop_front()));
        if (!rst && fs_en && !fs_we && fs_exp_q.size() > 0)
            check(fs_tag_q.pop_front(), 64'(fs_rdata), 64'(fs_exp_q.pop_front()));
    end

    task automatic drive_idle();
        lg_en = 0; lg_we = 0; lg_addr = '0; lg_wdata = '0;
        fs_en = 0; fs_we = 0; fs_addr = '0; fs_be = '0; fs_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; drive_idle();
        end
    endtask

    task automatic lg_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk); #1; drive_idle();
        lg_en = 1; lg_we = 1; lg_addr = a; lg_wdata = d;
    endtask

    task automatic lg_read(input logic [2:0] a, input logic [W-1:0] e, input string tag);
        @(negedge clk); #1; drive_idle();
        lg_en = 1; lg_addr = a;
        lg_exp_q.push_back(e); lg_tag_q.push_back(tag);
    endtask

    task automatic fs_write(input logic [3:0] a, input logic [3:0] b, input logic [W-1:0] d);
        @(negedge clk); #1; drive_idle();
        fs_en = 1; fs_we = 1; fs_addr = a; fs_be = b; fs_wdata = d;
    endtask

    task automatic fs_read(input logic [3:0] a, input logic [W-1:0] e, input string tag);
        @(negedge clk); #1; drive_idle();
        fs_en = 1; fs_addr = a;
        fs_exp_q.push_back(e); fs_tag_q.push_back(tag);
    endtask

    task automatic both_write(input logic [2:0] la, input logic [W-1:0] ld,
                              input logic [3:0] fa, input logic [W-1:0] fd);
        @(negedge clk); #1; drive_idle();
        lg_en = 1; lg_we = 1; lg_addr = la; lg_wdata = ld;
        fs_en = 1; fs_we = 1; fs_addr = fa; fs_be = 4'hF; fs_wdata = fd;
    endtask

    task automatic pin_check(input string tag, input logic [NP*W-1:0] eo,
                             input logic [NP*W-1:0] eoe);
        idle(1);
        @(negedge clk);
        check({tag, " pin_o"}, pin_o, eo);
        check({tag, " pin_oe"}, pin_oe, eoe);
    endtask

    task automatic run_tests();
        drive_idle();
        rst = 1; fast_mode = '0; pin_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check("R1 pin_oe after reset", pin_oe, '0);
        lg_read(3'd1, 0, "R1 lg set p0");
        lg_read(3'd2, 0, "R1 lg dir p0");
        lg_read(3'd6, 0, "R1 lg dir p1");
        fs_read(4'd0, 0, "R1 fs dir p0");
        fs_read(4'd1, 0, "R1 fs mask p0");
        fs_read(4'd11, 0, "R1 fs set p1");
        // Legacy port 0
        lg_write(3'd2, 32'hFFFF_0000);
        lg_write(3'd1, 32'h00F0_00F0);
        lg_read(3'd1, 32'h00F0_00F0, "R3 lg set");
        lg_write(3'd1, 32'h0F00_0000);
        lg_read(3'd1, 32'h0FF0_00F0, "R3 lg set zeros keep");
        lg_write(3'd3, 32'h0030_0010);
        lg_read(3'd1, 32'h0FC0_00E0, "R4 lg clear");
        lg_read(3'd3, 0, "R5 lg clear reads zero");
        pin_check("R12 R7 legacy p0", 64'h0000_0000_0FC0_00E0, 64'h0000_0000_FFFF_0000);
        // Fast bank separate
        fs_read(4'd3, 0, "R6 fs set untouched");
        fs_read(4'd0, 0, "R6 fs dir untouched");
        fs_write(4'd0, 4'b0011, 32'hFFFF_FFFF);
        fs_read(4'd0, 32'h0000_FFFF, "R10 fs dir lanes");
        fast_mode = 2'b01;
        pin_check("R7 fast p0", 64'h0, 64'h0000_0000_0000_FFFF);
        // Mask
        fs_write(4'd1, 4'hF, 32'h0000_00FF);
        fs_write(4'd3, 4'hF, 32'hFFFF_FFFF);
        fs_read(4'd3, 32'hFFFF_FF00, "R8 fs set masked");
        fs_write(4'd4, 4'hF, 32'h0000_0F0F);
        fs_read(4'd3, 32'hFFFF_F000, "R4 R8 fs clear masked");
        lg_read(3'd1, 32'h0FC0_00E0, "R6 lg set untouched");
        fs_write(4'd2, 4'b0101, 32'h1234_5678);
        fs_read(4'd3, 32'hFF34_F000, "R11 R10 fs pin write");
        // Pin readback
        @(negedge clk); pin_i = 64'h0000_0000_A5A5_5A5A;
        idle(3);
        lg_read(3'd0, 32'hA5A5_5A5A, "R2 lg pin readback");
        fs_read(4'd2, 32'hA5A5_5A00, "R9 fs pin masked");
        // Unmapped
        fs_write(4'd5, 4'hF, 32'hFFFF_FFFF);
        fs_read(4'd5, 0, "R5 fs unmapped read");
        fs_read(4'd0, 32'h0000_FFFF, "R5 dir after unmapped write");
        fs_read(4'd1, 32'h0000_00FF, "R5 mask after unmapped write");
        fs_read(4'd3, 32'hFF34_F000, "R5 set after unmapped write");
        fs_read(4'd4, 0, "R5 fs clear reads zero");
        // Port 1
        lg_write(3'd5, 32'hDEAD_BEEF);
        lg_read(3'd1, 32'h0FC0_00E0, "R6 p0 untouched by p1");
        lg_write(3'd4, 32'h0000_FFFF);
        lg_read(3'd5, 32'h0000_FFFF, "R3 lg pin write loads latch");
        // Same-cycle writes on both banks
        both_write(3'd5, 32'h0001_0000, 4'd11, 32'h8000_0000);
        lg_read(3'd5, 32'h0001_FFFF, "R6 lg p1 concurrent");
        fs_read(4'd11, 32'h8000_0000, "R6 fs p1 concurrent");
        pin_check("R7 p1 legacy", {32'h0001_FFFF, 32'hFF34_F000}, {32'h0, 32'h0000_FFFF});
        fast_mode = 2'b10;
        pin_check("R7 p1 fast", {32'h8000_0000, 32'h0FC0_00E0}, {32'h0, 32'hFFFF_0000});
        idle(2);
        if (lg_exp_q.size() != 0 || fs_exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", lg_exp_q.size() + fs_exp_q.size());
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                #2_000_000;
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule